// File: doc/BRIEF.md
# Pin Bank Controller with Interrupt Unit

This block drives and observes 64 general-purpose pins from a 32-bit word-addressed register bus. Every pin has its own output-data and output-enable register, placed as a pair on an 8-byte stride. The output enable is active low, so a pin comes out of reset as an input. All inputs pass through a two-flop synchronizer, and software reads them as two 32-bit words.

Every pin also feeds an interrupt unit. For each pin, software can select level or edge sensitivity, an active sense (high or low level, rising or falling edge), and an any-edge mode. Software sees a raw status and a status filtered by a per-pin mask. Edge events stay latched until software writes a one to that pin's bit in a clear register. One interrupt line reports whether any unmasked pin is active, and a global enable bit gates that line.

Each per-pin quantity is split over a pair of 32-bit words. The lower word holds pins 0 to 31 and the upper word, 4 bytes higher, holds pins 32 to 63. The read data path is combinational from the address. A write takes effect on the next rising clock edge.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset, all of the following hold: every output-enable bit reads 1 and every `pin_oe_n` bit is 1, every `pin_out` bit is 0, the global enable at 0x000 reads 0, all masks are 0 and `irq` is 0.
- R2: Pin n's output data is at 0x050+8n and its active-low output enable is at 0x054+8n. Only write-data bit 0 is stored, and reads return it in bit 0. An enable of 0 drives the stored data onto `pin_out[n]`.
- R3: The input words at 0x048 (pins 0-31) and 0x04C (pins 32-63) show `pin_in` two clock edges after it changes.
- R4: A pin whose type bit (0x010/0x014) is 0 is level sensitive. Its raw status (0x038/0x03C) is the synchronized input when its polarity bit (0x020/0x024) is 1, and the inverted input when that bit is 0.
- R5: A pin whose type bit is 1 and whose any-edge bit (0x018/0x01C) is 0 latches its raw status on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The opposite edge leaves the status unchanged, and the status stays set after the input returns. The status is visible one edge after the input word shows the change.
- R6: A pin whose type bit and any-edge bit are both 1 latches its raw status on either edge, whatever its polarity bit.
- R7: Writing 1 to a bit of the clear register (0x030/0x034) clears that pin's latched edge status. Writing 0 changes nothing, and the register reads as 0.
- R8: The raw status of a level-sensitive pin is not latched, and writes to the clear register do not affect it.
- R9: The masked status (0x040/0x044) equals the raw status ANDed with the mask bits (0x028/0x02C).
- R10: `irq` is 1 exactly when bit 0 of the global enable at 0x000 is 1 and at least one masked status bit is 1.
- R11: Bit k of each lower word belongs to pin k, and bit k of the word 4 bytes above it belongs to pin 32+k.
- R12: If an edge event and a clear write reach the same pin on the same clock edge, the status ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 64 | Asynchronous pin inputs |
| pin_out | output | 64 | Per-pin output data |
| pin_oe_n | output | 64 | Per-pin active-low output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A stale previous-value flop or a wrong polarity term shows up as a raw-status word that is set on the wrong edge. It appears exactly three clock edges after the pin toggles, one edge later than the input word. A latch that loses the race against a clear, or a clear that reaches level pins, shows up as a status word that drops in the cycle after the clear write. A mis-decoded word half or pin stride shows up at once as a wrong bit position in a readback or on `pin_out`/`pin_oe_n`. The checks therefore sample at the predicted edge, not at some later time.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 2;
    localparam int NUM_PINS  = WORD_W * NUM_WORDS;
    localparam int ADDR_W    = 12;
    localparam int IDX_W     = $clog2(NUM_PINS);

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_TYPE   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_ANY    = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_POL    = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_MSK_ST = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_INPUT  = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_PINREG = 12'h050;
    localparam logic [ADDR_W-1:0] OFS_PINEND = OFS_PINREG + ADDR_W'(NUM_PINS * 8);

    typedef struct packed {
        logic [NUM_PINS-1:0] edge_mode;
        logic [NUM_PINS-1:0] any_edge;
        logic [NUM_PINS-1:0] active_hi;
        logic [NUM_PINS-1:0] unmask;
    } irq_cfg_t;

    // true when addr falls in the 8-byte word pair starting at base
    function automatic logic in_pair(logic [ADDR_W-1:0] addr, logic [ADDR_W-1:0] base);
        return addr[ADDR_W-1:3] == base[ADDR_W-1:3];
    endfunction

    function automatic logic [WORD_W-1:0] half_of(logic [NUM_PINS-1:0] v, logic upper);
        return upper ? v[NUM_PINS-1:WORD_W] : v[WORD_W-1:0];
    endfunction

    function automatic logic [NUM_PINS-1:0] put_half(logic [NUM_PINS-1:0] v, logic upper,
                                                     logic [WORD_W-1:0] w);
        logic [NUM_PINS-1:0] r;
        r = v;
        if (upper) r[NUM_PINS-1:WORD_W] = w;
        else       r[WORD_W-1:0] = w;
        return r;
    endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync
    import gpio_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] async_i,
    output logic [NUM_PINS-1:0] sync_o
);
    logic [NUM_PINS-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] lvl_i,
    input  irq_cfg_t            cfg_i,
    input  logic [NUM_PINS-1:0] clr_i,
    output logic [NUM_PINS-1:0] raw_o
);
    logic [NUM_PINS-1:0] prev_q, held_q;
    logic [NUM_PINS-1:0] rise_w, fall_w, hit_w, level_w;

    assign rise_w  = lvl_i & ~prev_q;
    assign fall_w  = ~lvl_i & prev_q;
    assign hit_w   = cfg_i.edge_mode &
                     ((cfg_i.any_edge & (rise_w | fall_w)) |
                      (~cfg_i.any_edge & ((cfg_i.active_hi & rise_w) | (~cfg_i.active_hi & fall_w))));
    assign level_w = ~(lvl_i ^ cfg_i.active_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            held_q <= '0;
        end else begin
            prev_q <= lvl_i;
            held_q <= hit_w | (held_q & ~clr_i);
        end
    end

    assign raw_o = (cfg_i.edge_mode & held_q) | (~cfg_i.edge_mode & level_w);

    // an edge seen in one cycle is held in the next, even with a clear (R12)
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        ((($past(hit_w)) & ~held_q) == '0));

    // a held status only drops where a clear bit was written (R7)
    assert_clear_only_R7: assert property (@(posedge clk) disable iff (rst)
        ((($past(held_q) & ~$past(clr_i)) & ~held_q) == '0));

    // level pins do not move while their input and config are still (R8)
    assert_level_unlatched_R8: assert property (@(posedge clk) disable iff (rst)
        ($stable(lvl_i) && $stable(cfg_i.edge_mode) && $stable(cfg_i.active_hi))
        |-> $stable(raw_o & ~cfg_i.edge_mode));
endmodule

// File: rtl/gpio_irq_outreg.sv
module gpio_irq_outreg
    import gpio_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic                sel_oe_i,
    input  logic                bit_i,
    output logic [NUM_PINS-1:0] dout_o,
    output logic [NUM_PINS-1:0] oe_n_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic hit;
        assign hit = wr_i && (idx_i == IDX_W'(p));
        always_ff @(posedge clk) begin
            if (rst) begin
                dout_o[p] <= 1'b0;
                oe_n_o[p] <= 1'b1;
            end else if (hit) begin
                if (sel_oe_i) oe_n_o[p] <= bit_i;
                else          dout_o[p] <= bit_i;
            end
        end
    end

    // reset leaves every pin undriven (R1)
    assert_reset_input_R1: assert property (@(posedge clk)
        $past(rst) |-> ((&oe_n_o) && (dout_o == '0)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe_n,
    output logic                 irq
);
    irq_cfg_t            cfg_q;
    logic                glb_en_q;
    logic [NUM_PINS-1:0] lvl_w, raw_w, msk_w, clr_w;
    logic                aligned, upper, in_pins, pin_wr;
    logic [IDX_W-1:0]    pin_idx;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign upper   = bus_addr[2];
    assign in_pins = aligned && (bus_addr >= OFS_PINREG) && (bus_addr < OFS_PINEND);
    assign pin_idx = IDX_W'((bus_addr - OFS_PINREG) >> 3);
    assign pin_wr  = bus_wr && in_pins;

    assign clr_w = (bus_wr && aligned && in_pair(bus_addr, OFS_CLEAR))
                 ? put_half('0, upper, bus_wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            glb_en_q <= 1'b0;
        end else if (bus_wr && aligned) begin
            if (bus_addr[ADDR_W-1:2] == OFS_ENABLE[ADDR_W-1:2]) glb_en_q <= bus_wdata[0];
            if (in_pair(bus_addr, OFS_TYPE))
                cfg_q.edge_mode <= put_half(cfg_q.edge_mode, upper, bus_wdata);
            if (in_pair(bus_addr, OFS_ANY))
                cfg_q.any_edge  <= put_half(cfg_q.any_edge, upper, bus_wdata);
            if (in_pair(bus_addr, OFS_POL))
                cfg_q.active_hi <= put_half(cfg_q.active_hi, upper, bus_wdata);
            if (in_pair(bus_addr, OFS_MASK))
                cfg_q.unmask    <= put_half(cfg_q.unmask, upper, bus_wdata);
        end
    end

    gpio_irq_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_in),
        .sync_o  (lvl_w)
    );

    gpio_irq_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (lvl_w),
        .cfg_i (cfg_q),
        .clr_i (clr_w),
        .raw_o (raw_w)
    );

    gpio_irq_outreg u_outreg (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (pin_wr),
        .idx_i    (pin_idx),
        .sel_oe_i (upper),
        .bit_i    (bus_wdata[0]),
        .dout_o   (pin_out),
        .oe_n_o   (pin_oe_n)
    );

    assign msk_w = raw_w & cfg_q.unmask;
    assign irq   = glb_en_q && (|msk_w);

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (bus_addr[ADDR_W-1:2] == OFS_ENABLE[ADDR_W-1:2]) bus_rdata[0] = glb_en_q;
            else if (in_pair(bus_addr, OFS_TYPE))   bus_rdata = half_of(cfg_q.edge_mode, upper);
            else if (in_pair(bus_addr, OFS_ANY))    bus_rdata = half_of(cfg_q.any_edge, upper);
            else if (in_pair(bus_addr, OFS_POL))    bus_rdata = half_of(cfg_q.active_hi, upper);
            else if (in_pair(bus_addr, OFS_MASK))   bus_rdata = half_of(cfg_q.unmask, upper);
            else if (in_pair(bus_addr, OFS_RAW))    bus_rdata = half_of(raw_w, upper);
            else if (in_pair(bus_addr, OFS_MSK_ST)) bus_rdata = half_of(msk_w, upper);
            else if (in_pair(bus_addr, OFS_INPUT))  bus_rdata = half_of(lvl_w, upper);
            else if (in_pins) bus_rdata[0] = upper ? pin_oe_n[pin_idx] : pin_out[pin_idx];
        end
    end

    // the line never rises while the global enable is off (R10)
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> glb_en_q);

    // a pin raising the line must be unmasked (R9)
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((raw_w & cfg_q.unmask) != '0));
endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 out lo, 3 out hi, 4 oe_n lo, 5 oe_n hi
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out, pin_oe_n;
    logic        irq;

    int checks = 0, failures = 0;
    bit done = 0;
    item_t sb[$];

    always #4 clk = ~clk;

    gpio_irq_bank u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq(irq)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic expect_item(input int kind, input logic [11:0] a,
                               input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        expect_item(0, a, e, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expectations mid low phase and compares
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {31'b0, irq};
                    2: act = pin_out[31:0];
                    3: act = pin_out[63:32];
                    4: act = pin_oe_n[31:0];
                    default: act = pin_oe_n[63:32];
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        // R1 reset state
        rd(12'h054, 32'h1, "R1 oe pin0");
        rd(12'h000, 32'h0, "R1 enable");
        rd(12'h028, 32'h0, "R1 mask lo");
        expect_item(4, 12'h0, 32'hFFFF_FFFF, "R1 oe_n lo");
        expect_item(5, 12'h0, 32'hFFFF_FFFF, "R1 oe_n hi");
        expect_item(2, 12'h0, 32'h0, "R1 out lo");
        expect_item(1, 12'h0, 32'h0, "R1 irq");
        // R2 per-pin output registers
        wr(12'h050 + 12'd40, 32'h1);
        wr(12'h054 + 12'd40, 32'h0);
        expect_item(2, 12'h0, 32'h0000_0020, "R2 out pin5");
        expect_item(4, 12'h0, 32'hFFFF_FFDF, "R2 oe_n pin5");
        rd(12'h054 + 12'd40, 32'h0, "R2 oe read pin5");
        wr(12'h190, 32'hFFFF_FFFE);
        rd(12'h190, 32'h0, "R2 bit0 only pin40");
        wr(12'h190, 32'hFFFF_FFFF);
        rd(12'h190, 32'h1, "R2 readback pin40");
        expect_item(3, 12'h0, 32'h0000_0100, "R2 R11 out pin40");
        // R3 input words
        pin_in = {32'hCAFE_0001, 32'h1234_5678};
        idle(1);
        rd(12'h048, 32'h0, "R3 not yet after one edge");
        rd(12'h048, 32'h1234_5678, "R3 input lo");
        rd(12'h04C, 32'hCAFE_0001, "R3 R11 input hi");
        pin_in = '0;
        idle(3);
        // R4 level sense, R9 mask, R10 irq gating
        wr(12'h020, 32'h0000_0001);
        rd(12'h038, 32'hFFFF_FFFE, "R4 level mixed polarity");
        wr(12'h028, 32'h0000_0003);
        rd(12'h040, 32'h0000_0002, "R9 masked lo");
        expect_item(1, 12'h0, 32'h0, "R10 irq off when disabled");
        wr(12'h000, 32'h1);
        expect_item(1, 12'h0, 32'h1, "R10 irq on when enabled");
        pin_in[1:0] = 2'b11;
        idle(2);
        rd(12'h038, 32'hFFFF_FFFD, "R4 level follows input");
        rd(12'h040, 32'h0000_0001, "R9 masked follows");
        wr(12'h028, 32'h0);
        expect_item(1, 12'h0, 32'h0, "R10 irq off when masked");
        wr(12'h000, 32'h0);
        pin_in[1:0] = 2'b00;
        wr(12'h020, 32'hFFFF_FFFF);
        idle(3);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h038, 32'h0, "R5 edge start clean");
        // R5 rising
        pin_in[2] = 1'b1;
        idle(2);
        rd(12'h038, 32'h0, "R5 not before third edge");
        rd(12'h038, 32'h0000_0004, "R5 rising latched");
        pin_in[2] = 1'b0;
        idle(3);
        rd(12'h038, 32'h0000_0004, "R5 held after fall");
        // R5 falling
        wr(12'h020, ~32'h0000_0008);
        pin_in[3] = 1'b1;
        idle(3);
        rd(12'h038, 32'h0000_0004, "R5 rise ignored on falling pin");
        pin_in[3] = 1'b0;
        idle(3);
        rd(12'h038, 32'h0000_000C, "R5 falling latched");
        // R7 clear
        wr(12'h030, 32'h0);
        rd(12'h038, 32'h0000_000C, "R7 zero write no effect");
        rd(12'h030, 32'h0, "R7 clear reads zero");
        wr(12'h030, 32'h0000_0004);
        rd(12'h038, 32'h0000_0008, "R7 one clears bit");
        // R6 any-edge with polarity low
        wr(12'h018, 32'h0000_0010);
        wr(12'h020, ~32'h0000_0018);
        pin_in[4] = 1'b1;
        idle(3);
        rd(12'h038, 32'h0000_0018, "R6 rise latched despite polarity");
        wr(12'h028, 32'h0000_0008);
        rd(12'h040, 32'h0000_0008, "R9 masked edge");
        wr(12'h030, 32'h0000_0010);
        rd(12'h038, 32'h0000_0008, "R6 cleared");
        pin_in[4] = 1'b0;
        idle(3);
        rd(12'h038, 32'h0000_0018, "R6 fall latched");
        // R12 set beats clear
        wr(12'h030, 32'hFFFF_FFFF);
        rd(12'h038, 32'h0, "R12 all cleared");
        pin_in[2] = 1'b1;
        idle(2);
        wr(12'h030, 32'h0000_0004);
        rd(12'h038, 32'h0000_0004, "R12 set wins");
        // R8 / R11 upper word level
        wr(12'h028, 32'h0);
        wr(12'h024, 32'hFFFF_FFFF);
        pin_in[32] = 1'b1;
        idle(2);
        rd(12'h03C, 32'h0000_0001, "R11 raw hi pin32");
        wr(12'h034, 32'hFFFF_FFFF);
        rd(12'h03C, 32'h0000_0001, "R8 level ignores clear");
        wr(12'h02C, 32'h0000_0001);
        wr(12'h000, 32'h1);
        rd(12'h044, 32'h0000_0001, "R11 masked hi");
        rd(12'h040, 32'h0, "R11 masked lo clear");
        expect_item(1, 12'h0, 32'h1, "R10 irq from upper pin");
        wr(12'h000, 32'h0);
        expect_item(1, 12'h0, 32'h0, "R10 irq gated off");
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule